// File: doc/BRIEF.md
# Two-Part Interframe Deferral Timer

This block sits beside an Ethernet MAC transmitter and decides when a queued frame may begin. It measures the interframe gap in bit times. A single-cycle `bit_tick` strobe advances the count by one bit time. The gap length and the length of its first, restartable part are both programmable, with defaults of 96 and 60 bit times. When the count reaches the full gap, `tx_permit` rises. It stays high until the transmitter answers with `tx_launch`.

In half duplex, the gap begins when receive carrier drops. Medium activity during the first part clears the count, so the block yields to incoming traffic. After the first part, a pending transmit no longer yields: the block goes on to the full gap even if that causes a collision. A collision pulse early in the gap, where the transceiver's self-test pulse is expected, is not treated as activity. In full duplex, the gap starts when the block's own transmit activity ends, and carrier and collision are ignored.

The controller has four states:
- `ST_READY`: the gap is complete and `tx_permit` is high.
- `ST_TX`: a transmit is in progress and the count is held at zero.
- `ST_PART1`: the count is in the restartable first part.
- `ST_PART2`: the count is between the first-part length and the full gap.

The transitions are:
- *launch*: READY to TX, on `tx_launch`.
- *tx-end*: TX to a counting state, when `tx_active` is low.
- *restart*: PART1, PART2 or READY to a counting state, when the count is cleared.
- *advance*: PART1 to PART2, when the count reaches the effective first-part length.
- *complete*: PART1 or PART2 to READY, when the count reaches the gap length.

Top module: `ifg_defer_timer`

## Requirements
- R1: After reset, `tx_permit` is 1, so the first frame may start without a gap.
- R2: The count advances only in cycles where `bit_tick` is 1. With `bit_tick` high every cycle and no activity on the medium, `tx_permit` first reads 1 after `gap_bits`+1 rising edges, counting the edge that first samples `tx_active` low after a launch.
- R3: In half duplex, while the count is below the effective first-part length, a high `carrier_sense` holds the count at 0. Once carrier drops, a full `gap_bits` count follows before `tx_permit` rises.
- R4: In half duplex, `collision` has no effect while the count is below 40 bit times. From 40 on, it restarts the count exactly as carrier does.
- R5: Once the count is at or above the effective first-part length, the response to carrier or collision depends on `tx_pending`. If `tx_pending` is 1, the activity is ignored. If `tx_pending` is 0, the activity restarts the count. This also applies in `ST_READY`.
- R6: When `two_part_off` is 1, the effective first-part length is 0 and `part1_bits` is ignored. `gap_bits` still sets the gap.
- R7: A `part1_bits` value above `gap_bits` acts as `gap_bits`.
- R8: In full duplex, `carrier_sense` and `collision` never restart the count.
- R9: `tx_permit` stays 1 until `tx_launch` is sampled. After that, it reads 0 from the next edge. A `tx_launch` outside `ST_READY` is ignored.
- R10: A `part1_bits` value of 0 is legal, and the whole gap then behaves as the second part.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe, once per bit time |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| two_part_off | input | 1 | 1 = first-part length forced to 0 |
| gap_bits | input | CNT_W | Total gap length in bit times |
| part1_bits | input | CNT_W | First-part length in bit times |
| carrier_sense | input | 1 | Receive carrier present |
| collision | input | 1 | Collision indication |
| tx_active | input | 1 | Own transmitter is sending |
| tx_pending | input | 1 | A frame is waiting to be sent |
| tx_launch | input | 1 | Transmit start acknowledge |
| tx_permit | output | 1 | A pending frame may start |

## Verification
Two functions can act on the same edge. A medium event can arrive in the cycle the count crosses a boundary: the first-part limit, or the 40-bit collision mask. The bench provokes this by placing carrier at count 59 and at count 60, and collision at count 39 and at count 40, with a default first part of 60. Each outcome is judged by the number of edges until `tx_permit` rises. A restart adds the count reached plus one edge to the plain gap time, while an ignored event leaves the gap time unchanged.

// File: rtl/ifg_defer_pkg.sv
package ifg_defer_pkg;

    // Controller phases of the deferral timer
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_TX    = 2'd1,
        ST_PART1 = 2'd2,
        ST_PART2 = 2'd3
    } defer_state_e;

    localparam int DEF_GAP_BITS   = 96;
    localparam int DEF_PART1_BITS = 60;
    localparam int DEF_SQE_BITS   = 40;

endpackage

// File: rtl/ifg_part_limit.sv
// Derives the effective first-part length from the programmed values.
module ifg_part_limit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             two_part_off,
    input  logic [CNT_W-1:0] gap_bits,
    input  logic [CNT_W-1:0] part1_bits,
    output logic [CNT_W-1:0] part1_eff
);

    logic [CNT_W-1:0] clamped;

    always_comb begin
        clamped = (part1_bits > gap_bits) ? gap_bits : part1_bits;
        part1_eff = two_part_off ? '0 : clamped;
    end

    // The first part never extends past the whole gap
    assert_part1_within_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        part1_eff <= gap_bits);

    // The disable control zeroes the first part
    assert_off_zeroes_part1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        two_part_off |-> (part1_eff == '0));

endmodule

// File: rtl/ifg_medium_qual.sv
// Qualifies carrier and collision into one "medium busy" condition.
module ifg_medium_qual #(
    parameter int CNT_W    = 8,
    parameter int SQE_BITS = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_duplex,
    input  logic             carrier_sense,
    input  logic             collision,
    input  logic [CNT_W-1:0] gap_count,
    output logic             medium_busy
);

    localparam logic [CNT_W-1:0] SQE_LIMIT = CNT_W'(SQE_BITS);

    logic col_seen;

    always_comb begin
        // collision inside the self-test window is discarded
        col_seen    = collision && (gap_count >= SQE_LIMIT);
        medium_busy = !full_duplex && (carrier_sense || col_seen);
    end

    assert_fd_never_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |-> !medium_busy);

    assert_sqe_window_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier_sense && gap_count < SQE_LIMIT) |-> !medium_busy);

endmodule

// File: rtl/ifg_defer_fsm.sv
// State register, gap counter and permit output.
module ifg_defer_fsm
    import ifg_defer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             medium_busy,
    input  logic             tx_active,
    input  logic             tx_pending,
    input  logic             tx_launch,
    input  logic [CNT_W-1:0] gap_bits,
    input  logic [CNT_W-1:0] part1_eff,
    output logic [CNT_W-1:0] gap_count,
    output logic             tx_permit
);

    defer_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Phase implied by a count value under the current programming
    function automatic defer_state_e phase_of(input logic [CNT_W-1:0] c);
        if (c >= gap_bits)       return ST_READY;
        else if (c >= part1_eff) return ST_PART2;
        else                     return ST_PART1;
    endfunction

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_READY: begin
                if (tx_launch) begin
                    state_d = ST_TX;                     // launch
                    cnt_d   = '0;
                end else if (medium_busy && !tx_pending) begin
                    cnt_d   = '0;                        // restart
                    state_d = phase_of('0);
                end
            end
            ST_TX: begin
                cnt_d = '0;
                if (!tx_active) state_d = phase_of('0);  // tx-end
            end
            ST_PART1: begin
                if (medium_busy)                          cnt_d = '0;
                else if (bit_tick && cnt_q < gap_bits)    cnt_d = cnt_q + 1'b1;
                state_d = phase_of(cnt_d);               // advance / complete
            end
            ST_PART2: begin
                if (medium_busy && !tx_pending)           cnt_d = '0;
                else if (bit_tick && cnt_q < gap_bits)    cnt_d = cnt_q + 1'b1;
                state_d = phase_of(cnt_d);
            end
            default: begin
                state_d = ST_READY;
                cnt_d   = '1;
            end
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cnt_q   <= '1;      // saturated: gap already served
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output process
    always_comb begin
        tx_permit = (state_q == ST_READY);
        gap_count = cnt_q;
    end

    assert_permit_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_permit && tx_pending && !tx_launch) |=> tx_permit);

    assert_launch_drops_permit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_permit && tx_launch) |=> (!tx_permit && gap_count == '0));

    assert_no_tick_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PART1 || state_q == ST_PART2) && !bit_tick && !medium_busy)
            |=> $stable(gap_count));

    assert_part1_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PART1 && medium_busy) |=> (gap_count == '0 && !tx_permit));

    assert_part2_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PART2 && tx_pending && bit_tick)
            |=> (gap_count == $past(gap_count) + 1'b1));

endmodule

// File: rtl/ifg_defer_timer.sv
module ifg_defer_timer
    import ifg_defer_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SQE_BITS = DEF_SQE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             full_duplex,
    input  logic             two_part_off,
    input  logic [CNT_W-1:0] gap_bits,
    input  logic [CNT_W-1:0] part1_bits,
    input  logic             carrier_sense,
    input  logic             collision,
    input  logic             tx_active,
    input  logic             tx_pending,
    input  logic             tx_launch,
    output logic             tx_permit
);

    logic [CNT_W-1:0] part1_eff;
    logic [CNT_W-1:0] gap_count;
    logic             medium_busy;

    ifg_part_limit #(.CNT_W(CNT_W)) u_limit (
        .clk          (clk),
        .rst_n        (rst_n),
        .two_part_off (two_part_off),
        .gap_bits     (gap_bits),
        .part1_bits   (part1_bits),
        .part1_eff    (part1_eff)
    );

    ifg_medium_qual #(.CNT_W(CNT_W), .SQE_BITS(SQE_BITS)) u_medium (
        .clk           (clk),
        .rst_n         (rst_n),
        .full_duplex   (full_duplex),
        .carrier_sense (carrier_sense),
        .collision     (collision),
        .gap_count     (gap_count),
        .medium_busy   (medium_busy)
    );

    ifg_defer_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .medium_busy (medium_busy),
        .tx_active   (tx_active),
        .tx_pending  (tx_pending),
        .tx_launch   (tx_launch),
        .gap_bits    (gap_bits),
        .part1_eff   (part1_eff),
        .gap_count   (gap_count),
        .tx_permit   (tx_permit)
    );

    // Full-duplex activity can never hold back a granted gap
    assert_fd_permit_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex && tx_permit && !tx_launch) |=> tx_permit);

endmodule

// File: tb/ifg_defer_timer_tb_top.sv
module ifg_defer_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int NV = 17;

    typedef struct packed {
        logic        fd;
        logic        off;
        logic        pend;
        logic [1:0]  kind;   // 0 none, 1 carrier, 2 collision
        logic [7:0]  at;     // count value at which the pulse is seen
        logic [7:0]  gap;
        logic [7:0]  p1;
        logic [15:0] edges;  // expected edges until permit
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,2'd0,8'd0 ,8'd96,8'd60 ,16'd97 },  // R2 plain gap
        '{1'b1,1'b0,1'b1,2'd1,8'd10,8'd96,8'd60 ,16'd97 },  // R8 carrier ignored
        '{1'b1,1'b0,1'b1,2'd2,8'd50,8'd96,8'd60 ,16'd97 },  // R8 collision ignored
        '{1'b0,1'b0,1'b1,2'd1,8'd10,8'd96,8'd60 ,16'd108},  // R3 restart
        '{1'b0,1'b0,1'b1,2'd1,8'd59,8'd96,8'd60 ,16'd157},  // R3 last first-part count
        '{1'b0,1'b0,1'b1,2'd1,8'd60,8'd96,8'd60 ,16'd97 },  // R5 boundary commit
        '{1'b0,1'b0,1'b1,2'd1,8'd70,8'd96,8'd60 ,16'd97 },  // R5 pending ignores
        '{1'b0,1'b0,1'b0,2'd1,8'd70,8'd96,8'd60 ,16'd168},  // R5 idle yields
        '{1'b0,1'b0,1'b1,2'd2,8'd20,8'd96,8'd60 ,16'd97 },  // R4 masked
        '{1'b0,1'b0,1'b1,2'd2,8'd39,8'd96,8'd60 ,16'd97 },  // R4 last masked
        '{1'b0,1'b0,1'b1,2'd2,8'd40,8'd96,8'd60 ,16'd138},  // R4 first unmasked
        '{1'b0,1'b0,1'b1,2'd2,8'd70,8'd96,8'd60 ,16'd97 },  // R5 collision ignored
        '{1'b0,1'b1,1'b1,2'd1,8'd10,8'd96,8'd60 ,16'd97 },  // R6 no first part
        '{1'b0,1'b0,1'b1,2'd1,8'd90,8'd96,8'd120,16'd188},  // R7 clamp
        '{1'b0,1'b0,1'b1,2'd1,8'd5 ,8'd50,8'd0  ,16'd51 },  // R10 zero first part
        '{1'b0,1'b0,1'b1,2'd1,8'd30,8'd40,8'd20 ,16'd41 },  // R2 short gap
        '{1'b0,1'b1,1'b0,2'd1,8'd10,8'd96,8'd60 ,16'd108}   // R6 idle yields
    };

    function automatic string tag_of(input int i);
        case (i)
            1, 2:            return "R8";
            3, 4:            return "R3";
            5, 6, 7, 11:     return "R5";
            8, 9, 10:        return "R4";
            12, 16:          return "R6";
            13:              return "R7";
            14:              return "R10";
            default:         return "R2";
        endcase
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b1;
    logic full_duplex = 1'b0;
    logic two_part_off = 1'b0;
    logic [CW-1:0] gap_bits = 8'd96;
    logic [CW-1:0] part1_bits = 8'd60;
    logic carrier_sense = 1'b0;
    logic collision = 1'b0;
    logic tx_active = 1'b0;
    logic tx_pending = 1'b0;
    logic tx_launch = 1'b0;
    logic tx_permit;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifg_defer_timer #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .full_duplex(full_duplex),
        .two_part_off(two_part_off), .gap_bits(gap_bits), .part1_bits(part1_bits),
        .carrier_sense(carrier_sense), .collision(collision), .tx_active(tx_active),
        .tx_pending(tx_pending), .tx_launch(tx_launch), .tx_permit(tx_permit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // launch from READY, then release tx_active
    task automatic launch_frame();
        @(negedge clk);
        tx_launch = 1'b1;
        tx_active = 1'b1;
        @(negedge clk);
        tx_launch = 1'b0;
        tx_active = 1'b0;
    endtask

    // count edges until permit; optional single-edge pulse at a count value
    task automatic edges_to_permit(input logic [1:0] kind, input int at,
                                   input bit stray_launch, output int n);
        bit done = 1'b0;
        n = 0;
        while (!done && n < 1000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (tx_permit) done = 1'b1;
            carrier_sense = !done && kind == 2'd1 && n == at + 1;
            collision     = !done && kind == 2'd2 && n == at + 1;
            tx_launch     = !done && stray_launch && n == at + 1;
        end
        carrier_sense = 1'b0;
        collision     = 1'b0;
        tx_launch     = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: permit straight after reset
        check(tx_permit == 1'b1, "R1", int'(tx_permit), 1);

        // R9: permit held while pending and not launched
        tx_pending = 1'b1;
        repeat (20) @(negedge clk);
        check(tx_permit == 1'b1, "R9", int'(tx_permit), 1);
        tx_launch = 1'b1;
        tx_active = 1'b1;
        @(negedge clk);
        tx_launch = 1'b0;
        check(tx_permit == 1'b0, "R9", int'(tx_permit), 0);
        tx_active = 1'b0;
        edges_to_permit(2'd0, 0, 1'b0, n);

        // table walk
        for (int i = 0; i < NV; i++) begin
            full_duplex  = VECS[i].fd;
            two_part_off = VECS[i].off;
            tx_pending   = VECS[i].pend;
            gap_bits     = VECS[i].gap;
            part1_bits   = VECS[i].p1;
            launch_frame();
            edges_to_permit(VECS[i].kind, int'(VECS[i].at), 1'b0, n);
            check(n == int'(VECS[i].edges), tag_of(i), n, int'(VECS[i].edges));
        end

        // R2: no tick, no progress
        full_duplex = 1'b0; two_part_off = 1'b0; tx_pending = 1'b1;
        gap_bits = 8'd10; part1_bits = 8'd4;
        bit_tick = 1'b0;
        launch_frame();
        repeat (30) @(negedge clk);
        check(tx_permit == 1'b0, "R2", int'(tx_permit), 0);
        bit_tick = 1'b1;
        n = 0;
        while (!tx_permit && n < 100) begin @(negedge clk); n++; end
        check(n == 10, "R2", n, 10);

        // R3: long carrier holds, then a full gap; idle READY yields (R5)
        gap_bits = 8'd96; part1_bits = 8'd60; tx_pending = 1'b0;
        @(negedge clk);
        carrier_sense = 1'b1;
        repeat (50) @(negedge clk);
        check(tx_permit == 1'b0, "R3", int'(tx_permit), 0);
        carrier_sense = 1'b0;
        n = 0;
        while (!tx_permit && n < 300) begin @(negedge clk); n++; end
        check(n == 96, "R3", n, 96);

        // R9: stray launch during the gap is ignored
        tx_pending = 1'b1; gap_bits = 8'd20; part1_bits = 8'd10;
        launch_frame();
        edges_to_permit(2'd0, 5, 1'b1, n);
        check(n == 21, "R9", n, 21);

        // R1: reset mid-gap restores permit
        gap_bits = 8'd96; part1_bits = 8'd60;
        launch_frame();
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_permit == 1'b1, "R1", int'(tx_permit), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule